// File: doc/BRIEF.md
# Auto-Indexed Block Data Buffer

This block holds the payload bytes of a block-mode transfer on a two-wire system management bus. Software and the transfer engine reach the same byte store through two separate paths. Software sees a single data window. Behind that window an internal index picks the entry, and the index moves on by one after every accepted read or write. The index returns to entry zero as a side effect of any read of the host control register, which reaches the block as a one-cycle pulse.

The transfer engine uses its own sequential pointer. That pointer returns to entry zero at the start of every transaction, whatever the software index holds. The engine stores received bytes through the pointer, or fetches bytes to send through it. The pointer stops when the store is full.

A byte-count register sits beside the store. Before a write transaction, software loads it with the number of bytes to send. During a read transaction, the engine loads it with the number the remote device returned. A count of zero, or one larger than the store, is reported to the control unit as invalid.

While the transaction-busy input is high, software accesses have no effect. While it is low, engine accesses have no effect.

Top module: `smbb_buf`

## Requirements
- R1: After reset every store entry reads 0x00, the software index and the engine pointer are 0, the count is 0, `cnt_bad_o` is 1 and `eng_full_o` is 0.
- R2: With `busy_i` low, a `sw_wr_i` pulse stores `sw_wdata_i` at the software index and a `sw_rd_i` pulse only consumes a byte. In both cases the index then advances by one, and `sw_rdata_o` always shows the entry at the current index.
- R3: The software index wraps from the last entry (31 by default) back to entry 0.
- R4: A `ctl_rd_i` pulse sets the software index to 0 on the next cycle. It takes priority over a software access in the same cycle.
- R5: While `busy_i` is high, `sw_wr_i`, `sw_rd_i` and `cnt_wr_i` have no effect. The store, the index and the count are unchanged.
- R6: An `eng_start_i` pulse sets the engine pointer to 0 on the next cycle, whatever the software index holds, and it clears `eng_full_o`.
- R7: With `busy_i` high, `eng_wr_i` stores `eng_wdata_i` at the engine pointer and `eng_rd_i` consumes a byte. In both cases the pointer then advances by one, and `eng_rdata_o` shows the entry at the pointer.
- R8: After as many engine accesses as the store has entries, the pointer stops and `eng_full_o` is 1. Further engine writes change no entry, and `eng_rdata_o` reads 0x00.
- R9: The count register takes `cnt_wdata_i` when `cnt_wr_i` is high and `busy_i` is low. It takes `eng_cnt_i` when `eng_cnt_wr_i` is high and `busy_i` is high. The new value appears on `cnt_o` one cycle later.
- R10: `cnt_bad_o` is 1 exactly when the count is 0 or greater than the number of store entries.
- R11: While `busy_i` is low, `eng_wr_i` and `eng_rd_i` change neither the store nor the engine pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | A transaction is running |
| ctl_rd_i | input | 1 | Pulse: host control register was read |
| sw_wr_i | input | 1 | Software write of the data window |
| sw_rd_i | input | 1 | Software read of the data window |
| sw_wdata_i | input | 8 | Software write byte |
| sw_rdata_o | output | 8 | Entry at the software index |
| cnt_wr_i | input | 1 | Software write of the count |
| cnt_wdata_i | input | 8 | Software count value |
| cnt_o | output | 8 | Current byte count |
| cnt_bad_o | output | 1 | Count is zero or exceeds store size |
| eng_start_i | input | 1 | Pulse: transaction starts, pointer to zero |
| eng_wr_i | input | 1 | Engine stores a received byte |
| eng_rd_i | input | 1 | Engine consumes a byte to send |
| eng_wdata_i | input | 8 | Engine received byte |
| eng_rdata_o | output | 8 | Entry at the engine pointer, 0 when full |
| eng_cnt_wr_i | input | 1 | Engine writes the received count |
| eng_cnt_i | input | 8 | Engine received count |
| eng_full_o | output | 1 | Engine pointer reached the end |

## Verification
The bench builds the block with its defaults: 32 entries, 8-bit bytes and an 8-bit count. With 32 entries, one loop of 32 writes is enough to show the index wrap and the engine pointer stopping at the end. Because the pointer can reach 32 while the store index has only five bits, the bench can also check that an engine write past the end does not alias onto entry zero. An 8-bit count can hold 33, so the just-too-large case is checked next to 32 and 0.

// File: rtl/smbb_pkg.sv
package smbb_pkg;
   // Count is invalid when zero or larger than the store
   function automatic logic count_invalid(input logic [15:0] cnt, input int unsigned depth);
      return (cnt == 16'd0) || (cnt > 16'(depth));
   endfunction
endpackage

// File: rtl/smbb_index.sv
module smbb_index #(
   parameter int unsigned IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             step_i,
   output logic [IDX_W-1:0] idx_o
);
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx_q <= '0;
      else if (clr_i)  idx_q <= '0;
      else if (step_i) idx_q <= idx_q + 1'b1;
   end

   assign idx_o = idx_q;

   // R4: a clear pulse lands the index on entry zero
   a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (idx_o == '0));

   // R2 and R3: a step moves the index one entry forward, modulo the depth
   a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !clr_i) |=> (idx_o == IDX_W'($past(idx_o) + 1'b1)));
endmodule

// File: rtl/smbb_engptr.sv
module smbb_engptr #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned PTR_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             step_i,
   output logic [PTR_W-1:0] ptr_o,
   output logic             full_o
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH);

   logic [PTR_W-1:0] ptr_q;
   logic             at_end;

   assign at_end = (ptr_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ptr_q <= '0;
      else if (start_i)           ptr_q <= '0;
      else if (step_i && !at_end) ptr_q <= ptr_q + 1'b1;
   end

   assign ptr_o  = ptr_q;
   assign full_o = at_end;

   // R8: the pointer never runs past the end of the store
   always_comb begin
      if (rst_n) a_r8_cap: assert (ptr_q <= LAST);
   end

   // R6: a start pulse returns the pointer to entry zero
   a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (ptr_o == '0) && !full_o);
endmodule

// File: rtl/smbb_store.sv
module smbb_store #(
   parameter int unsigned DEPTH     = 32,
   parameter int unsigned DW        = 8,
   parameter int unsigned IDX_W     = 5,
   parameter bit          RST_CLEAR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_a_i,
   input  logic [IDX_W-1:0] addr_a_i,
   input  logic [DW-1:0]    wd_a_i,
   input  logic             we_b_i,
   input  logic [IDX_W-1:0] addr_b_i,
   input  logic [DW-1:0]    wd_b_i,
   input  logic [IDX_W-1:0] raddr_a_i,
   output logic [DW-1:0]    rd_a_o,
   input  logic [IDX_W-1:0] raddr_b_i,
   output logic [DW-1:0]    rd_b_o
);
   logic [DW-1:0] mem [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic hit_a, hit_b;
      assign hit_a = we_a_i && (addr_a_i == IDX_W'(e));
      assign hit_b = we_b_i && (addr_b_i == IDX_W'(e));
      if (RST_CLEAR) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     mem[e] <= '0;
            else if (hit_b) mem[e] <= wd_b_i;
            else if (hit_a) mem[e] <= wd_a_i;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit_b)      mem[e] <= wd_b_i;
            else if (hit_a) mem[e] <= wd_a_i;
         end
      end
   end

   assign rd_a_o = mem[raddr_a_i];
   assign rd_b_o = mem[raddr_b_i];
endmodule

// File: rtl/smbb_count.sv
module smbb_count #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned DEPTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_we_i,
   input  logic [CNT_W-1:0] sw_val_i,
   input  logic             eng_we_i,
   input  logic [CNT_W-1:0] eng_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             bad_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (eng_we_i) cnt_q <= eng_val_i;
      else if (sw_we_i)  cnt_q <= sw_val_i;
   end

   assign cnt_o = cnt_q;
   assign bad_o = smbb_pkg::count_invalid(16'(cnt_q), DEPTH);

   // R9: the count holds unless one of its two writers fires
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_we_i && !eng_we_i) |=> $stable(cnt_o));
endmodule

// File: rtl/smbb_buf.sv
module smbb_buf #(
   parameter int unsigned DEPTH     = 32,
   parameter int unsigned DW        = 8,
   parameter int unsigned CNT_W     = 8,
   parameter bit          RST_CLEAR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy_i,
   input  logic             ctl_rd_i,
   input  logic             sw_wr_i,
   input  logic             sw_rd_i,
   input  logic [DW-1:0]    sw_wdata_i,
   output logic [DW-1:0]    sw_rdata_o,
   input  logic             cnt_wr_i,
   input  logic [CNT_W-1:0] cnt_wdata_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             cnt_bad_o,
   input  logic             eng_start_i,
   input  logic             eng_wr_i,
   input  logic             eng_rd_i,
   input  logic [DW-1:0]    eng_wdata_i,
   output logic [DW-1:0]    eng_rdata_o,
   input  logic             eng_cnt_wr_i,
   input  logic [CNT_W-1:0] eng_cnt_i,
   output logic             eng_full_o
);
   localparam int unsigned IDX_W = $clog2(DEPTH);
   localparam int unsigned PTR_W = IDX_W + 1;

   initial begin
      a_depth_pow2: assert (DEPTH >= 2 && DEPTH == (1 << IDX_W))
         else $error("DEPTH must be a power of two");
      a_cnt_fits: assert ((1 << CNT_W) > DEPTH)
         else $error("CNT_W too narrow for DEPTH");
   end

   logic             sw_go, sw_we, eng_go, eng_we;
   logic [IDX_W-1:0] sw_idx;
   logic [PTR_W-1:0] eng_ptr;
   logic             eng_full;
   logic [DW-1:0]    eng_rd_raw;

   assign sw_go  = !busy_i && (sw_wr_i || sw_rd_i);
   assign sw_we  = !busy_i && sw_wr_i;
   assign eng_go = busy_i && (eng_wr_i || eng_rd_i) && !eng_full;
   assign eng_we = busy_i && eng_wr_i && !eng_full;

   smbb_index #(.IDX_W(IDX_W)) u_index (
      .clk(clk), .rst_n(rst_n), .clr_i(ctl_rd_i), .step_i(sw_go), .idx_o(sw_idx));

   smbb_engptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_engptr (
      .clk(clk), .rst_n(rst_n), .start_i(eng_start_i), .step_i(eng_go),
      .ptr_o(eng_ptr), .full_o(eng_full));

   smbb_store #(.DEPTH(DEPTH), .DW(DW), .IDX_W(IDX_W), .RST_CLEAR(RST_CLEAR)) u_store (
      .clk(clk), .rst_n(rst_n),
      .we_a_i(sw_we), .addr_a_i(sw_idx), .wd_a_i(sw_wdata_i),
      .we_b_i(eng_we), .addr_b_i(eng_ptr[IDX_W-1:0]), .wd_b_i(eng_wdata_i),
      .raddr_a_i(sw_idx), .rd_a_o(sw_rdata_o),
      .raddr_b_i(eng_ptr[IDX_W-1:0]), .rd_b_o(eng_rd_raw));

   smbb_count #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_count (
      .clk(clk), .rst_n(rst_n),
      .sw_we_i(!busy_i && cnt_wr_i), .sw_val_i(cnt_wdata_i),
      .eng_we_i(busy_i && eng_cnt_wr_i), .eng_val_i(eng_cnt_i),
      .cnt_o(cnt_o), .bad_o(cnt_bad_o));

   assign eng_rdata_o = eng_full ? '0 : eng_rd_raw;
   assign eng_full_o  = eng_full;

   // R5: software cannot move the index during a transaction
   a_r5_idx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !ctl_rd_i) |=> $stable(sw_idx));

   // R11: the engine pointer rests while no transaction runs
   a_r11_ptr_rest: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && !eng_start_i) |=> $stable(eng_ptr));

   // R8: once full, the engine sees zero data
   a_r8_full_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_full_o && !eng_start_i) |=> (eng_rdata_o == '0));
endmodule

// File: tb/smbb_buf_bench.sv
module smbb_buf_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       busy_i = 0, ctl_rd_i = 0, sw_wr_i = 0, sw_rd_i = 0, cnt_wr_i = 0;
   logic       eng_start_i = 0, eng_wr_i = 0, eng_rd_i = 0, eng_cnt_wr_i = 0;
   logic [7:0] sw_wdata_i = 0, cnt_wdata_i = 0, eng_wdata_i = 0, eng_cnt_i = 0;
   logic [7:0] sw_rdata_o, cnt_o, eng_rdata_o;
   logic       cnt_bad_o, eng_full_o;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   smbb_buf u_smbb_buf (
      .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .ctl_rd_i(ctl_rd_i),
      .sw_wr_i(sw_wr_i), .sw_rd_i(sw_rd_i), .sw_wdata_i(sw_wdata_i), .sw_rdata_o(sw_rdata_o),
      .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i), .cnt_o(cnt_o), .cnt_bad_o(cnt_bad_o),
      .eng_start_i(eng_start_i), .eng_wr_i(eng_wr_i), .eng_rd_i(eng_rd_i),
      .eng_wdata_i(eng_wdata_i), .eng_rdata_o(eng_rdata_o),
      .eng_cnt_wr_i(eng_cnt_wr_i), .eng_cnt_i(eng_cnt_i), .eng_full_o(eng_full_o));

   // op[19:16]: 0 write, 1 read, 2 control read, 3 write while busy, 4 read while busy
   // data[15:8], expected sw_rdata_o after the step[7:0]
   localparam logic [23:0] VEC [0:8] = '{
      24'h00A100,  // R2 write at 0
      24'h00B200,  // R2 write at 1
      24'h0200A1,  // R4 back to 0
      24'h0100B2,  // R2 read advances
      24'h0355B2,  // R5 write ignored
      24'h0400B2,  // R5 read ignored
      24'h00C300,  // R2 overwrite entry 1
      24'h0200A1,  // R4
      24'h0100C3   // R2
   };

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      ctl_rd_i = 0; sw_wr_i = 0; sw_rd_i = 0; cnt_wr_i = 0;
      eng_start_i = 0; eng_wr_i = 0; eng_rd_i = 0; eng_cnt_wr_i = 0;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 sw_rdata", sw_rdata_o, 8'h00);
      chk("R1 eng_rdata", eng_rdata_o, 8'h00);
      chk("R1 count", cnt_o, 8'h00);
      chk("R1 R10 cnt_bad", cnt_bad_o, 1'b1);
      chk("R1 eng_full", eng_full_o, 1'b0);

      for (int i = 0; i < 9; i++) begin
         case (VEC[i][19:16])
            4'd0: begin sw_wr_i = 1; sw_wdata_i = VEC[i][15:8]; end
            4'd1: sw_rd_i = 1;
            4'd2: ctl_rd_i = 1;
            4'd3: begin busy_i = 1; sw_wr_i = 1; sw_wdata_i = VEC[i][15:8]; end
            default: begin busy_i = 1; sw_rd_i = 1; end
         endcase
         tick();
         busy_i = 0;
         chk($sformatf("R2/R4/R5 vector %0d", i), sw_rdata_o, VEC[i][7:0]);
      end

      // R3 wrap after a full pass of writes
      ctl_rd_i = 1; tick();
      for (int i = 0; i < 32; i++) begin
         sw_wr_i = 1; sw_wdata_i = 8'(8'h10 + i); tick();
      end
      chk("R3 wrap to entry 0", sw_rdata_o, 8'h10);
      sw_rd_i = 1; sw_wr_i = 1; ctl_rd_i = 1; sw_wdata_i = 8'hEE; tick();
      chk("R4 clear beats access", sw_rdata_o, 8'hEE);
      sw_rd_i = 1; tick();
      chk("R3 R2 read after wrap", sw_rdata_o, 8'h11);

      // R6 R7 engine path, software index sits at 1
      busy_i = 1; eng_start_i = 1; tick();
      chk("R6 engine starts at 0", eng_rdata_o, 8'hEE);
      chk("R6 sw index untouched", sw_rdata_o, 8'h11);
      eng_rd_i = 1; tick();
      chk("R7 engine read advances", eng_rdata_o, 8'h11);
      eng_start_i = 1; tick();
      eng_wr_i = 1; eng_wdata_i = 8'hE0; tick();
      eng_wr_i = 1; eng_wdata_i = 8'hE1; tick();
      chk("R7 engine pointer at 2", eng_rdata_o, 8'h12);
      eng_cnt_wr_i = 1; eng_cnt_i = 8'd2; tick();
      chk("R9 engine count", cnt_o, 8'd2);
      busy_i = 0;
      eng_wr_i = 1; eng_wdata_i = 8'h99; tick();
      chk("R11 idle engine write ignored", eng_rdata_o, 8'h12);
      ctl_rd_i = 1; tick();
      chk("R7 engine byte 0 stored", sw_rdata_o, 8'hE0);
      sw_rd_i = 1; tick();
      chk("R7 engine byte 1 stored", sw_rdata_o, 8'hE1);

      // R9 R10 count register
      cnt_wr_i = 1; cnt_wdata_i = 8'd5; tick();
      chk("R9 sw count", cnt_o, 8'd5);
      chk("R10 count 5 valid", cnt_bad_o, 1'b0);
      cnt_wr_i = 1; cnt_wdata_i = 8'd33; tick();
      chk("R10 count 33 invalid", cnt_bad_o, 1'b1);
      cnt_wr_i = 1; cnt_wdata_i = 8'd32; tick();
      chk("R10 count 32 valid", cnt_bad_o, 1'b0);
      busy_i = 1; cnt_wr_i = 1; cnt_wdata_i = 8'd7; tick();
      busy_i = 0;
      chk("R5 busy count write ignored", cnt_o, 8'd32);
      cnt_wr_i = 1; cnt_wdata_i = 8'd0; tick();
      chk("R10 count 0 invalid", cnt_bad_o, 1'b1);

      // R8 engine cap
      busy_i = 1; eng_start_i = 1; tick();
      for (int i = 0; i < 32; i++) begin
         eng_wr_i = 1; eng_wdata_i = 8'(8'h40 + i); tick();
      end
      chk("R8 full flag", eng_full_o, 1'b1);
      chk("R8 full reads zero", eng_rdata_o, 8'h00);
      eng_wr_i = 1; eng_wdata_i = 8'hFF; tick();
      busy_i = 0;
      ctl_rd_i = 1; tick();
      chk("R8 write past end no alias", sw_rdata_o, 8'h40);
      busy_i = 1; eng_start_i = 1; tick();
      chk("R6 start clears full", eng_full_o, 1'b0);
      chk("R6 R8 entry 0 after restart", eng_rdata_o, 8'h40);
      busy_i = 0;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule